// File: doc/BRIEF.md
# Dual Base-and-Bound Address Translator

This block relocates and range-checks every memory access of a simple in-order core. Two translation lanes work side by side in the same cycle. The fetch lane takes the program counter and uses the code segment's base and limit. The data lane takes the effective address of a load or store and uses the data segment's base and limit. Each lane adds its segment base to the logical address to form the physical address. Each lane also compares the logical address against the segment limit. Any address at or above the limit is flagged as a fault, and the lane's valid output is withheld so that downstream logic drops the access.

The four segment registers sit behind a small configuration port with a 2-bit select. Software running in supervisor mode writes and reads them. A write attempted in user mode leaves every register unchanged and raises a one-cycle privilege-error pulse. A read attempted in user mode returns zero. After reset every base and limit is zero, so each access faults until software sets up the segments.

Top module: `dual_seg_xlate`

## Requirements
- R1: For each lane, the physical address output equals the logical address plus that lane's segment base, modulo 2^32. It is combinational in the same cycle.
- R2: A lane with its request high raises its fault output exactly when the logical address is greater than or equal to its segment limit (unsigned). Its valid output is request AND NOT fault.
- R3: The physical address output is still driven during a fault.
- R4: The fetch lane uses select code 0 (code base) and code 1 (code limit). The data lane uses select code 2 (data base) and code 3 (data limit).
- R5: With sup_mode_i high, a cfg_we_i pulse loads cfg_wdata_i into the register picked by cfg_sel_i at the clock edge. The new value governs translation from the next cycle on.
- R6: With sup_mode_i low, a cfg_we_i pulse changes no register. priv_err_o is high for exactly the one cycle after that edge.
- R7: cfg_rdata_o returns the register picked by cfg_sel_i while sup_mode_i is high, and returns zero while it is low.
- R8: After reset all four registers are zero, priv_err_o is low, and every request faults.
- R9: With its request low, a lane drives valid and fault low. The two lanes are evaluated independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sup_mode_i | input | 1 | Core is in supervisor mode |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select: 0 code base, 1 code limit, 2 data base, 3 data limit |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Selected register in supervisor mode, otherwise zero |
| priv_err_o | output | 1 | One-cycle pulse after a user-mode write attempt |
| if_req_i | input | 1 | Fetch request |
| if_laddr_i | input | 32 | Program counter (logical) |
| if_paddr_o | output | 32 | Fetch physical address |
| if_valid_o | output | 1 | Fetch may proceed |
| if_fault_o | output | 1 | Fetch outside code segment |
| dt_req_i | input | 1 | Data request |
| dt_laddr_i | input | 32 | Effective address (logical) |
| dt_paddr_o | output | 32 | Data physical address |
| dt_valid_o | output | 1 | Data access may proceed |
| dt_fault_o | output | 1 | Data access outside data segment |

## Verification
The assertions check several rules on every cycle. A user-mode write leaves the register bank untouched and is followed by exactly one error pulse. A supervisor write lands in the selected register. Each lane's fault and valid agree with its request and with the limit held in the register bank. Other behaviour shows only in the bench's scenarios, which compare against values computed independently. These cover the correct addition of base to address, including wrap-around, and the routing of each lane to its own register pair. They also cover the exact boundary where the address equals the limit, the masking of reads in user mode, and the all-faulting state after reset.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int unsigned NUM_SEG_REGS = 4;
  localparam int unsigned SEL_W = $clog2(NUM_SEG_REGS);

  typedef enum logic [SEL_W-1:0] {
    SEL_CODE_BASE  = 2'd0,
    SEL_CODE_LIMIT = 2'd1,
    SEL_DATA_BASE  = 2'd2,
    SEL_DATA_LIMIT = 2'd3
  } seg_sel_e;

  localparam int unsigned NUM_LANES = 2;
  localparam int unsigned LANE_CODE = 0;
  localparam int unsigned LANE_DATA = 1;
endpackage

// File: rtl/seg_regs.sv
module seg_regs
  import seg_xlate_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              sup_mode_i,
  input  logic                              we_i,
  input  logic [SEL_W-1:0]                  sel_i,
  input  logic [AW-1:0]                     wdata_i,
  output logic [AW-1:0]                     rdata_o,
  output logic                              priv_err_o,
  output logic [NUM_SEG_REGS-1:0][AW-1:0]   regs_o
);
  logic [NUM_SEG_REGS-1:0][AW-1:0] regs_q;
  logic                            err_q;
  logic                            wr_ok, wr_bad;

  assign wr_ok  = we_i & sup_mode_i;
  assign wr_bad = we_i & ~sup_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= wr_bad;
      if (wr_ok) regs_q[sel_i] <= wdata_i;
    end
  end

  assign regs_o     = regs_q;
  assign priv_err_o = err_q;
  assign rdata_o    = sup_mode_i ? regs_q[sel_i] : '0;

  assert_user_write_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !sup_mode_i) |=> $stable(regs_q));

  assert_user_write_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !sup_mode_i) |=> priv_err_o);

  assert_pulse_has_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_err_o |-> $past(we_i && !sup_mode_i));

  assert_sup_write_lands_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sup_mode_i) |=> regs_q[$past(sel_i)] == $past(wdata_i));
endmodule

// File: rtl/seg_lane.sv
module seg_lane #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] laddr_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] limit_i,
  output logic [AW-1:0] paddr_o,
  output logic          valid_o,
  output logic          fault_o
);
  logic over;

  assign over    = laddr_i >= limit_i;
  assign paddr_o = laddr_i + base_i;  // driven even on fault
  assign fault_o = req_i & over;
  assign valid_o = req_i & ~over;

  assert_one_outcome_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> (valid_o ^ fault_o));

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !(valid_o || fault_o));
endmodule

// File: rtl/dual_seg_xlate.sv
module dual_seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sup_mode_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_sel_i,
  input  logic [AW-1:0]    cfg_wdata_i,
  output logic [AW-1:0]    cfg_rdata_o,
  output logic             priv_err_o,
  input  logic             if_req_i,
  input  logic [AW-1:0]    if_laddr_i,
  output logic [AW-1:0]    if_paddr_o,
  output logic             if_valid_o,
  output logic             if_fault_o,
  input  logic             dt_req_i,
  input  logic [AW-1:0]    dt_laddr_i,
  output logic [AW-1:0]    dt_paddr_o,
  output logic             dt_valid_o,
  output logic             dt_fault_o
);
  logic [NUM_SEG_REGS-1:0][AW-1:0] regs;
  logic [NUM_LANES-1:0]            req, valid, fault;
  logic [NUM_LANES-1:0][AW-1:0]    laddr, paddr;

  seg_regs #(.AW(AW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sup_mode_i (sup_mode_i),
    .we_i       (cfg_we_i),
    .sel_i      (cfg_sel_i),
    .wdata_i    (cfg_wdata_i),
    .rdata_o    (cfg_rdata_o),
    .priv_err_o (priv_err_o),
    .regs_o     (regs)
  );

  assign req[LANE_CODE]   = if_req_i;
  assign laddr[LANE_CODE] = if_laddr_i;
  assign req[LANE_DATA]   = dt_req_i;
  assign laddr[LANE_DATA] = dt_laddr_i;

  // lane k uses register pair {2k, 2k+1}: base then limit
  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    seg_lane #(.AW(AW)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (req[k]),
      .laddr_i (laddr[k]),
      .base_i  (regs[2*k]),
      .limit_i (regs[2*k+1]),
      .paddr_o (paddr[k]),
      .valid_o (valid[k]),
      .fault_o (fault[k])
    );
  end

  assign if_paddr_o = paddr[LANE_CODE];
  assign if_valid_o = valid[LANE_CODE];
  assign if_fault_o = fault[LANE_CODE];
  assign dt_paddr_o = paddr[LANE_DATA];
  assign dt_valid_o = valid[LANE_DATA];
  assign dt_fault_o = fault[LANE_DATA];

  assert_code_limit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (if_req_i && (if_laddr_i >= regs[SEL_CODE_LIMIT])) |-> if_fault_o);

  assert_data_limit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dt_req_i && (dt_laddr_i >= regs[SEL_DATA_LIMIT])) |-> dt_fault_o);

  assert_valid_inside_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dt_valid_o |-> (dt_laddr_i < regs[SEL_DATA_LIMIT]));
endmodule

// File: tb/dual_seg_xlate_test.sv
module dual_seg_xlate_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sup = 1'b0, we = 1'b0;
  logic [1:0]  sel = '0;
  logic [31:0] wdata = '0, rdata;
  logic        perr;
  logic        if_req = 1'b0, dt_req = 1'b0;
  logic [31:0] if_la = '0, dt_la = '0, if_pa, dt_pa;
  logic        if_v, if_f, dt_v, dt_f;

  int unsigned tests = 0, fails = 0;
  bit          done = 1'b0;
  logic [31:0] model [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_seg_xlate uut (
    .clk_i(clk), .rst_ni(rst_n), .sup_mode_i(sup), .cfg_we_i(we),
    .cfg_sel_i(sel), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .priv_err_o(perr),
    .if_req_i(if_req), .if_laddr_i(if_la), .if_paddr_o(if_pa),
    .if_valid_o(if_v), .if_fault_o(if_f),
    .dt_req_i(dt_req), .dt_laddr_i(dt_la), .dt_paddr_o(dt_pa),
    .dt_valid_o(dt_v), .dt_fault_o(dt_f)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // lane 0 = code (regs 0,1), lane 1 = data (regs 2,3)
  function automatic logic [31:0] exp_pa(int lane, logic [31:0] la);
    return la + model[2*lane];
  endfunction
  function automatic logic exp_fault(int lane, logic req, logic [31:0] la);
    return req && (la >= model[2*lane+1]);
  endfunction

  task automatic cfg_write(input logic [1:0] s, input logic [31:0] d, input logic sm);
    @(negedge clk);
    sup = sm; sel = s; wdata = d; we = 1'b1;
    @(posedge clk);
    if (sm) model[s] = d;
    #1 we = 1'b0;
    chk(perr == !sm, sm ? "R5 no err on sup write" : "R6 err pulse", {31'd0, perr}, {31'd0, !sm});
    @(posedge clk); #1;
    chk(perr == 1'b0, "R6 pulse one cycle", {31'd0, perr}, 32'd0);
  endtask

  task automatic probe(input logic ir, input logic [31:0] ia, input logic dr, input logic [31:0] da);
    logic ef;
    @(negedge clk);
    if_req = ir; if_la = ia; dt_req = dr; dt_la = da;
    #1;
    chk(if_pa == exp_pa(0, ia), "R1 R4 code paddr", if_pa, exp_pa(0, ia));
    chk(dt_pa == exp_pa(1, da), "R1 R4 data paddr", dt_pa, exp_pa(1, da));
    ef = exp_fault(0, ir, ia);
    chk(if_f == ef && if_v == (ir && !ef), "R2 R9 code fault/valid", {30'd0, if_v, if_f}, {30'd0, ir && !ef, ef});
    ef = exp_fault(1, dr, da);
    chk(dt_f == ef && dt_v == (dr && !ef), "R2 R9 data fault/valid", {30'd0, dt_v, dt_f}, {30'd0, dr && !ef, ef});
  endtask

  task automatic read_chk(input logic [1:0] s, input logic sm);
    logic [31:0] e;
    @(negedge clk);
    sel = s; sup = sm; #1;
    e = sm ? model[s] : 32'd0;
    chk(rdata == e, "R7 readback", rdata, e);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) model[i] = '0;
    void'($urandom(32'd5150));
    repeat (3) @(posedge clk);
    #1;
    // R8: reset state
    chk(perr == 1'b0, "R8 reset perr", {31'd0, perr}, 32'd0);
    chk(if_f == 1'b0 && dt_f == 1'b0, "R8 idle after reset", {30'd0, if_f, dt_f}, 32'd0);
    rst_n = 1'b1;
    for (int s = 0; s < 4; s++) read_chk(2'(s), 1'b1);
    probe(1'b1, 32'd0, 1'b1, 32'h1234);  // R8: limit 0 -> all fault
    chk(if_f && dt_f, "R8 all fault", {30'd0, if_f, dt_f}, 32'd3);
    probe(1'b1, 32'h55, 1'b1, 32'hffff_ffff);
    probe(1'b0, 32'h10, 1'b0, 32'h20);

    // R5 configure
    cfg_write(2'd0, 32'h0001_0000, 1'b1);
    cfg_write(2'd1, 32'h0000_1000, 1'b1);
    cfg_write(2'd2, 32'h0008_0000, 1'b1);
    cfg_write(2'd3, 32'h0000_4000, 1'b1);
    for (int s = 0; s < 4; s++) read_chk(2'(s), 1'b1);
    for (int s = 0; s < 4; s++) read_chk(2'(s), 1'b0);   // R7 user read masked
    // R2 boundary: limit-1 ok, limit faults, R3 paddr still driven
    probe(1'b1, 32'h0fff, 1'b1, 32'h3fff);
    probe(1'b1, 32'h1000, 1'b1, 32'h4000);
    chk(if_pa == 32'h0001_1000, "R3 paddr during fault", if_pa, 32'h0001_1000);
    // R4 lanes separate: addr fits data but not code
    probe(1'b1, 32'h2000, 1'b1, 32'h2000);
    chk(if_f && dt_v, "R4 R9 independent lanes", {30'd0, if_f, dt_v}, 32'd3);
    // R6 user-mode write ignored, observed via translation and readback
    cfg_write(2'd0, 32'hdead_0000, 1'b0);
    cfg_write(2'd3, 32'h0000_0000, 1'b0);
    probe(1'b1, 32'h10, 1'b1, 32'h10);
    chk(if_pa == 32'h0001_0010 && dt_v, "R6 regs untouched", if_pa, 32'h0001_0010);
    read_chk(2'd0, 1'b1);
    // R1 wrap-around
    cfg_write(2'd2, 32'hffff_fff0, 1'b1);
    probe(1'b0, 32'h0, 1'b1, 32'h20);
    chk(dt_pa == 32'h10, "R1 wrap", dt_pa, 32'h10);
    cfg_write(2'd3, 32'hffff_ffff, 1'b1);
    probe(1'b0, 32'h0, 1'b1, 32'hffff_fffe);
    probe(1'b0, 32'h0, 1'b1, 32'hffff_ffff);

    // random mix
    for (int n = 0; n < 300; n++) begin
      int unsigned r = $urandom_range(0, 9);
      if (r < 2) begin
        cfg_write(2'($urandom_range(0, 3)), $urandom(), 1'($urandom_range(0, 1)));
      end else if (r < 3) begin
        read_chk(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
      end else begin
        logic [31:0] a, b;
        a = (r < 6) ? model[1] + 32'($signed($urandom_range(0, 4)) - 2) : $urandom();
        b = (r < 6) ? model[3] + 32'($signed($urandom_range(0, 4)) - 2) : $urandom();
        probe(1'($urandom_range(0, 1)), a, 1'($urandom_range(0, 1)), b);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule